// File: doc/BRIEF.md
# Double-Scan Key Matrix Controller

This block watches a key matrix of up to six drive lines and five sense lines. While idle it holds the drive lines at a rest pattern chosen by the power-save setting. When a sense line goes high it starts scanning: it raises one drive line at a time and samples the sense lines at the end of that line's window. It runs two full passes back to back. A key state is accepted only if both passes return the same non-empty result. The accepted state is masked for the current key-count and power-save settings and then latched, and an active-low request is raised on the serial data output.

The host reads the result over a chip-select and shift-clock pair. It opens a read cycle by raising chip-select while the shift clock is low. Thirty key bits come out, then a flag that shows whether a power-save mode is active. While a request is pending, scanning stops and the latched bits stay as they are. When the read cycle closes, the request clears and scanning can start again. A write cycle is the same chip-select rise with the shift clock high. It only releases the output high while it lasts, and the first completed write cycle after reset enables scanning. One clock period stands for one oscillator period.

Top module: `keyscan_ctrl`

## Requirements
- R1: A scan raises exactly one drive line at a time, in order from line 0 to line 5. Each line stays high for 48 clocks, so one pass lasts 288 clocks and the second pass begins with line 0 again on clock 288.
- R2: When two consecutive passes agree and hold at least one key, `hs_out` goes low on the 577th rising edge counted from the edge that put drive line 0 high.
- R3: If the two passes disagree and the second one saw a key, a new pair of passes starts at once. If the second pass saw no key, the block returns to idle and raises no request.
- R4: While the request is pending, no scan starts, the drive lines stay at the idle pattern and the latched bits do not change. When a read cycle ends, `hs_out` returns high.
- R5: The idle drive pattern depends on `save_mode`. For 00 (normal) and 11 (save 3) all six lines are high. For 01 (save 1) only line 5 is high. For 10 (save 2) only lines 4 and 5 are high. A scan starts only when some sense input is high while the block is idle.
- R6: Key bit n (counting from 1) is drive line (n-1)/5 and sense line (n-1)%5. With `key_mode` 01 (25 keys), bits 1 to 5 are latched as 0. With `key_mode` 1x (20 keys), bits 1 to 10 are latched as 0. With 00 (30 keys), no bits are masked.
- R7: With `save_mode` 01, bits 1 to 25 are latched as 0. With `save_mode` 10, bits 1 to 20 are latched as 0.
- R8: A read cycle starts when `hs_cs` rises while `hs_clk` is low. `hs_out` then shows bit 1, and each falling edge of `hs_clk` moves it to the next bit. The 31st value is the power-save flag, which is 1 when `save_mode` is not 00. After that the output stays high.
- R9: A write cycle (`hs_cs` rising while `hs_clk` is high) holds `hs_out` high while `hs_cs` stays high. A pending request shows low again once `hs_cs` falls.
- R10: After reset, the key buffer is zero, `hs_out` is high and no scan starts until the first write cycle has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one period is one oscillator period |
| rst_n | input | 1 | Synchronous active-low reset |
| key_mode | input | 2 | Key-count select: 00 = 30 keys, 01 = 25 keys, 1x = 20 keys |
| save_mode | input | 2 | Power-save select: 00 normal, 01/10/11 save 1/2/3 |
| sense_in | input | 5 | Matrix sense lines, high when a pressed key meets a high drive line |
| hs_cs | input | 1 | Host chip select (asynchronous) |
| hs_clk | input | 1 | Host shift clock (asynchronous) |
| drive_out | output | 6 | Matrix drive lines |
| hs_out | output | 1 | Open-drain level: low means request pending, or carries read data |

## Verification
The bench counts clocks from the edge where drive line 0 first goes high. It checks the request on exactly clock 577 and not one clock earlier, so an off-by-one in the dwell counter or in the latch hand-off shows up. It changes the pressed key between the two passes. A design that trusted a single pass would report the wrong key too early, and one that retried after a release would raise a request for nothing. It changes the pressed key while a request is pending. A block that kept scanning would overwrite the held data. It also runs key-count and power-save masks with keys on masked and unmasked lines, where a misplaced mask boundary shows as a wrong bit in the shifted word. Finally it presses a key on a line that is low in the idle pattern, where a design that ignored the rest pattern would start a scan.

// File: rtl/keyscan_pkg.sv
// Shared encodings for the key matrix controller.
// Assumes two-bit power-save and key-count selects as listed in the brief.
package keyscan_pkg;

    localparam logic [1:0] PS_NORMAL = 2'b00;
    localparam logic [1:0] PS_ONE    = 2'b01;
    localparam logic [1:0] PS_TWO    = 2'b10;
    localparam logic [1:0] PS_THREE  = 2'b11;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'b00,
        SEQ_SCAN = 2'b01,
        SEQ_CMP  = 2'b10
    } seq_state_t;

    typedef enum logic [1:0] {
        HOST_IDLE  = 2'b00,
        HOST_READ  = 2'b01,
        HOST_WRITE = 2'b10
    } host_mode_t;

endpackage

// File: rtl/keyscan_seq.sv
// Scan sequencer: drives the rest pattern while idle and, on a sensed key,
// runs two passes of one-hot drive, each line held for DWELL clocks with the
// sense lines sampled in the last clock of the window. It offers the result
// when both passes agree and are non-empty.
// Assumes sense_i is already synchronous to clk.
module keyscan_seq
    import keyscan_pkg::*;
#(
    parameter int DRV   = 6,
    parameter int SNS   = 5,
    parameter int DWELL = 48
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic              hold_i,
    input  logic [1:0]        psave_i,
    input  logic [SNS-1:0]    sense_i,
    output logic [DRV-1:0]    drive_o,
    output logic              fix_vld_o,
    output logic [DRV*SNS-1:0] fix_bits_o
);
    localparam int NB = DRV * SNS;
    localparam int CW = $clog2(DWELL);
    localparam int LW = $clog2(DRV);

    seq_state_t       state;
    logic [CW-1:0]    dwell_cnt;
    logic [LW-1:0]    line_idx;
    logic             pass_q;
    logic [NB-1:0]    first_q;
    logic [NB-1:0]    second_q;
    logic [DRV-1:0]   idle_pat;
    logic             agree;
    logic             any_hit;
    logic             window_end;

    assign window_end = (dwell_cnt == CW'(DWELL - 1));
    assign agree      = (first_q == second_q);
    assign any_hit    = |second_q;

    // Rest pattern of the drive lines for the current power-save select.
    always_comb begin
        for (int i = 0; i < DRV; i++) begin
            case (psave_i)
                PS_ONE:  idle_pat[i] = (i == DRV - 1);
                PS_TWO:  idle_pat[i] = (i >= DRV - 2);
                default: idle_pat[i] = 1'b1;
            endcase
        end
    end

    // Drive output: one-hot while scanning, rest pattern otherwise.
    always_comb begin
        drive_o = idle_pat;
        if (state == SEQ_SCAN) begin
            drive_o = '0;
            drive_o[line_idx] = 1'b1;
        end
    end

    assign fix_vld_o  = (state == SEQ_CMP) && agree && any_hit;
    assign fix_bits_o = second_q;

    // Pass sequencing, sampling and comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            dwell_cnt <= '0;
            line_idx  <= '0;
            pass_q    <= 1'b0;
            first_q   <= '0;
            second_q  <= '0;
        end else begin
            case (state)
                SEQ_IDLE: begin
                    if (enable_i && !hold_i && |sense_i) begin
                        state     <= SEQ_SCAN;
                        dwell_cnt <= '0;
                        line_idx  <= '0;
                        pass_q    <= 1'b0;
                    end
                end
                SEQ_SCAN: begin
                    if (window_end) begin
                        if (pass_q) second_q[int'(line_idx)*SNS +: SNS] <= sense_i;
                        else        first_q[int'(line_idx)*SNS +: SNS]  <= sense_i;
                        dwell_cnt <= '0;
                        if (line_idx == LW'(DRV - 1)) begin
                            line_idx <= '0;
                            if (pass_q) state <= SEQ_CMP;
                            else        pass_q <= 1'b1;
                        end else begin
                            line_idx <= line_idx + 1'b1;
                        end
                    end else begin
                        dwell_cnt <= dwell_cnt + 1'b1;
                    end
                end
                SEQ_CMP: begin
                    if (!agree && any_hit) begin
                        state     <= SEQ_SCAN;
                        dwell_cnt <= '0;
                        line_idx  <= '0;
                        pass_q    <= 1'b0;
                    end else begin
                        state <= SEQ_IDLE;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // R1: drive lines stay put inside a dwell window.
    assert_drive_steady_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_SCAN && !window_end) |=> $stable(drive_o));

    // R2: a fixed result only ever follows the end of a second pass.
    assert_fix_after_second_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fix_vld_o |-> $past(state == SEQ_SCAN && pass_q));

    // R4: a pending request keeps the sequencer idle.
    assert_hold_blocks_scan_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && hold_i) |=> (state == SEQ_IDLE));

    // R10: no scan before the first completed write.
    assert_no_scan_before_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_IDLE && !enable_i) |=> (state == SEQ_IDLE));

endmodule

// File: rtl/keyscan_hold.sv
// Result holder: masks an agreed scan result by key-count and power-save
// selects, latches it and keeps a pending flag until a read completes.
// Assumes fix_vld_i and rd_done_i never come in the same cycle.
module keyscan_hold
    import keyscan_pkg::*;
#(
    parameter int DRV = 6,
    parameter int SNS = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fix_vld_i,
    input  logic [DRV*SNS-1:0] fix_bits_i,
    input  logic [1:0]         keymode_i,
    input  logic [1:0]         psave_i,
    input  logic               rd_done_i,
    output logic [DRV*SNS-1:0] key_buf_o,
    output logic               pending_o
);
    localparam int NB = DRV * SNS;

    logic [NB-1:0] keep_mask;
    int            lo_key;
    int            lo_save;
    int            lo_line;

    // Number of low drive lines whose bits are forced to zero.
    always_comb begin
        lo_key  = keymode_i[1] ? 2 : (keymode_i[0] ? 1 : 0);
        case (psave_i)
            PS_ONE:  lo_save = DRV - 1;
            PS_TWO:  lo_save = DRV - 2;
            default: lo_save = 0;
        endcase
        lo_line = (lo_key > lo_save) ? lo_key : lo_save;
        for (int b = 0; b < NB; b++) keep_mask[b] = ((b / SNS) >= lo_line);
    end

    // Latch on agreement, clear the request once the host has read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_buf_o <= '0;
            pending_o <= 1'b0;
        end else if (fix_vld_i) begin
            key_buf_o <= fix_bits_i & keep_mask;
            pending_o <= 1'b1;
        end else if (rd_done_i) begin
            pending_o <= 1'b0;
        end
    end

    // R4: held data does not move while waiting for the host.
    assert_buffer_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pending_o && !fix_vld_i) |=> $stable(key_buf_o));

    // R6: twenty-key mode leaves the first two lines empty.
    assert_twenty_key_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_vld_i && keymode_i[1]) |=> (key_buf_o[2*SNS-1:0] == '0));

    // R7: save 1 leaves every line but the last empty.
    assert_save_one_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_vld_i && psave_i == PS_ONE) |=> (key_buf_o[(DRV-1)*SNS-1:0] == '0));

endmodule

// File: rtl/keyscan_host.sv
// Host port: synchronises chip select and shift clock, tells read cycles from
// write cycles by the shift-clock level at the select rise, shifts out the
// held bits and flag, and enables scanning after the first write.
// Assumes the host toggles its lines slower than a few clk periods.
module keyscan_host
    import keyscan_pkg::*;
#(
    parameter int NB = 30
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_i,
    input  logic          sclk_i,
    input  logic [NB-1:0] key_buf_i,
    input  logic          psave_flag_i,
    input  logic          pending_i,
    output logic          sdo_o,
    output logic          scan_en_o,
    output logic          rd_done_o
);
    localparam int IW = $clog2(NB + 2);

    logic       cs_m, cs_s, cs_d;
    logic       sclk_m, sclk_s, sclk_d;
    logic       cs_rise, cs_fall, sclk_fall;
    host_mode_t mode;
    logic [IW-1:0] rd_idx;

    // Two-stage synchronisers plus one delay stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {cs_m, cs_s, cs_d}       <= '0;
            {sclk_m, sclk_s, sclk_d} <= '0;
        end else begin
            {cs_m, cs_s, cs_d}       <= {cs_i, cs_m, cs_s};
            {sclk_m, sclk_s, sclk_d} <= {sclk_i, sclk_m, sclk_s};
        end
    end

    assign cs_rise   = cs_s & ~cs_d;
    assign cs_fall   = ~cs_s & cs_d;
    assign sclk_fall = sclk_d & ~sclk_s;
    assign rd_done_o = (mode == HOST_READ) && cs_fall;

    // Cycle type, bit pointer and scan enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode      <= HOST_IDLE;
            rd_idx    <= '0;
            scan_en_o <= 1'b0;
        end else begin
            case (mode)
                HOST_IDLE: begin
                    if (cs_rise) begin
                        mode   <= sclk_s ? HOST_WRITE : HOST_READ;
                        rd_idx <= '0;
                    end
                end
                HOST_READ: begin
                    if (cs_fall) mode <= HOST_IDLE;
                    else if (sclk_fall && rd_idx != IW'(NB + 1)) rd_idx <= rd_idx + 1'b1;
                end
                HOST_WRITE: begin
                    if (cs_fall) begin
                        mode      <= HOST_IDLE;
                        scan_en_o <= 1'b1;
                    end
                end
                default: mode <= HOST_IDLE;
            endcase
        end
    end

    // Output level: read data, released during writes, else request.
    always_comb begin
        case (mode)
            HOST_READ: begin
                if (rd_idx < IW'(NB))       sdo_o = key_buf_i[rd_idx];
                else if (rd_idx == IW'(NB)) sdo_o = psave_flag_i;
                else                        sdo_o = 1'b1;
            end
            HOST_WRITE: sdo_o = 1'b1;
            default:    sdo_o = ~pending_i;
        endcase
    end

    // R8: a select rise with the shift clock low opens a read.
    assert_read_on_low_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HOST_IDLE && cs_rise && !sclk_s) |=> (mode == HOST_READ));

    // R9: a write cycle does not clear a pending request.
    assert_write_keeps_request_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HOST_WRITE && pending_i) |=> pending_i);

endmodule

// File: rtl/keyscan_ctrl.sv
// Top of the double-scan key matrix controller: joins the scan sequencer,
// the result holder and the host port.
// Assumes sense_in is synchronous to clk; host lines may be asynchronous.
module keyscan_ctrl
    import keyscan_pkg::*;
#(
    parameter int DRV_LINES = 6,
    parameter int SNS_LINES = 5,
    parameter int DWELL     = 48
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           key_mode,
    input  logic [1:0]           save_mode,
    input  logic [SNS_LINES-1:0] sense_in,
    input  logic                 hs_cs,
    input  logic                 hs_clk,
    output logic [DRV_LINES-1:0] drive_out,
    output logic                 hs_out
);
    localparam int NB = DRV_LINES * SNS_LINES;

    logic          scan_en;
    logic          pending;
    logic          fix_vld;
    logic [NB-1:0] fix_bits;
    logic [NB-1:0] key_buf;
    logic          rd_done;

    keyscan_seq #(.DRV(DRV_LINES), .SNS(SNS_LINES), .DWELL(DWELL)) i_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (scan_en),
        .hold_i     (pending),
        .psave_i    (save_mode),
        .sense_i    (sense_in),
        .drive_o    (drive_out),
        .fix_vld_o  (fix_vld),
        .fix_bits_o (fix_bits)
    );

    keyscan_hold #(.DRV(DRV_LINES), .SNS(SNS_LINES)) i_hold (
        .clk        (clk),
        .rst_n      (rst_n),
        .fix_vld_i  (fix_vld),
        .fix_bits_i (fix_bits),
        .keymode_i  (key_mode),
        .psave_i    (save_mode),
        .rd_done_i  (rd_done),
        .key_buf_o  (key_buf),
        .pending_o  (pending)
    );

    keyscan_host #(.NB(NB)) i_host (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_i         (hs_cs),
        .sclk_i       (hs_clk),
        .key_buf_i    (key_buf),
        .psave_flag_i (save_mode != PS_NORMAL),
        .pending_i    (pending),
        .sdo_o        (hs_out),
        .scan_en_o    (scan_en),
        .rd_done_o    (rd_done)
    );

endmodule

// File: tb/test_keyscan_ctrl.sv
// Directed bench for keyscan_ctrl: models the key matrix, counts clocks from
// scan start and reads results through the host port.
module test_keyscan_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] key_mode = 2'b00;
    logic [1:0] save_mode = 2'b00;
    logic [4:0] sense_in;
    logic       hs_cs = 1'b0;
    logic       hs_clk = 1'b0;
    logic [5:0] drive_out;
    logic       hs_out;

    logic [5:0][4:0] pressed = '0;
    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Matrix model: a pressed key connects its drive line to its sense line.
    always_comb begin
        for (int j = 0; j < 5; j++) begin
            sense_in[j] = 1'b0;
            for (int i = 0; i < 6; i++) sense_in[j] = sense_in[j] | (pressed[i][j] & drive_out[i]);
        end
    end

    keyscan_ctrl i_keyscan_ctrl (
        .clk(clk), .rst_n(rst_n), .key_mode(key_mode), .save_mode(save_mode),
        .sense_in(sense_in), .hs_cs(hs_cs), .hs_clk(hs_clk),
        .drive_out(drive_out), .hs_out(hs_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wait_to(input int n);
        while (cyc < n) @(negedge clk);
    endtask

    task automatic host_write(input bit chk_release);
        @(negedge clk); hs_clk = 1'b1;
        repeat (4) @(negedge clk);
        hs_cs = 1'b1;
        repeat (8) @(negedge clk);
        if (chk_release) check(hs_out == 1'b1, "R9", "output during write", hs_out, 1);
        hs_cs = 1'b0;
        repeat (8) @(negedge clk);
        hs_clk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic host_read(output logic [31:0] v);
        @(negedge clk); hs_clk = 1'b0;
        repeat (4) @(negedge clk);
        hs_cs = 1'b1;
        repeat (8) @(negedge clk);
        v[0] = hs_out;
        for (int k = 1; k < 32; k++) begin
            hs_clk = 1'b1;
            repeat (5) @(negedge clk);
            hs_clk = 1'b0;
            repeat (6) @(negedge clk);
            v[k] = hs_out;
        end
        hs_cs = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    // Waits for drive line 0 to go high on its own; returns the clock count then.
    task automatic wait_start(output int c0);
        int guard = 0;
        while (drive_out != 6'b000001 && guard < 3000) begin
            @(negedge clk); guard++;
        end
        check(drive_out == 6'b000001, "R5", "scan start", drive_out, 1);
        c0 = cyc;
    endtask

    // Checks the request lands exactly 577 edges after the start edge.
    task automatic expect_request(input int c_start, input string req);
        wait_to(c_start + 576);
        check(hs_out == 1'b1, req, "request one clock early", hs_out, 1);
        @(negedge clk);
        check(hs_out == 1'b0, req, "request at 577", hs_out, 0);
    endtask

    task automatic read_expect(input logic [29:0] keys, input bit psf, input string req);
        logic [31:0] got;
        logic [31:0] exp;
        host_read(got);
        exp = {1'b1, psf, keys};
        check(got == exp, req, "shifted word", got, exp);
        check(hs_out == 1'b1, "R4", "request released after read", hs_out, 1);
    endtask

    task automatic t_reset;
        check(hs_out == 1'b1, "R10", "output after reset", hs_out, 1);
        check(drive_out == 6'h3F, "R5", "normal idle drive", drive_out, 6'h3F);
    endtask

    task automatic t_no_scan_before_enable;
        @(negedge clk); pressed[2][3] = 1'b1;
        repeat (1000) @(negedge clk);
        check(drive_out == 6'h3F, "R10", "drive before enable", drive_out, 6'h3F);
        check(hs_out == 1'b1, "R10", "no request before enable", hs_out, 1);
        pressed = '0;
        read_expect(30'h0, 1'b0, "R10");
    endtask

    task automatic t_basic_scan;
        int c0;
        host_write(1'b0);
        @(negedge clk); pressed[2][3] = 1'b1;
        wait_start(c0);
        wait_to(c0 + 47);
        check(drive_out == 6'b000001, "R1", "line0 end of window", drive_out, 1);
        @(negedge clk);
        check(drive_out == 6'b000010, "R1", "line1 after 48", drive_out, 2);
        wait_to(c0 + 287);
        check(drive_out == 6'b100000, "R1", "line5 last clock", drive_out, 6'h20);
        @(negedge clk);
        check(drive_out == 6'b000001, "R1", "second pass begins", drive_out, 1);
        expect_request(c0, "R2");
        pressed = '0;
        read_expect(30'h1 << 13, 1'b0, "R8");
    endtask

    task automatic t_hold_and_write;
        int c0;
        @(negedge clk); pressed[1][0] = 1'b1;
        wait_start(c0);
        expect_request(c0, "R2");
        pressed = '0; pressed[3][4] = 1'b1;
        repeat (1500) @(negedge clk);
        check(hs_out == 1'b0, "R4", "request held", hs_out, 0);
        check(drive_out == 6'h3F, "R4", "no scan while held", drive_out, 6'h3F);
        host_write(1'b1);
        check(hs_out == 1'b0, "R9", "request back after write", hs_out, 0);
        pressed = '0;
        read_expect(30'h1 << 5, 1'b0, "R4");
    endtask

    task automatic t_disagree;
        int c0;
        @(negedge clk); pressed[2][3] = 1'b1;
        wait_start(c0);
        wait_to(c0 + 300);
        pressed = '0; pressed[4][0] = 1'b1;
        wait_to(c0 + 582);
        check(hs_out == 1'b1, "R3", "no request after mismatch", hs_out, 1);
        expect_request(c0 + 577, "R3");
        pressed = '0;
        read_expect(30'h1 << 20, 1'b0, "R3");
    endtask

    task automatic t_release_mid;
        int c0;
        @(negedge clk); pressed[2][3] = 1'b1;
        wait_start(c0);
        wait_to(c0 + 300);
        pressed = '0;
        wait_to(c0 + 1300);
        check(hs_out == 1'b1, "R3", "no request after release", hs_out, 1);
        check(drive_out == 6'h3F, "R3", "idle after release", drive_out, 6'h3F);
    endtask

    task automatic t_key_modes;
        int c0;
        key_mode = 2'b01;
        @(negedge clk); pressed[0][1] = 1'b1; pressed[3][2] = 1'b1;
        wait_start(c0);
        expect_request(c0, "R2");
        pressed = '0;
        read_expect(30'h1 << 17, 1'b0, "R6");
        key_mode = 2'b10;
        @(negedge clk); pressed[1][4] = 1'b1; pressed[2][0] = 1'b1;
        wait_start(c0);
        expect_request(c0, "R2");
        pressed = '0;
        read_expect(30'h1 << 10, 1'b0, "R6");
        key_mode = 2'b00;
    endtask

    task automatic t_save_modes;
        int c0;
        save_mode = 2'b01;
        @(negedge clk);
        check(drive_out == 6'b100000, "R5", "save 1 idle drive", drive_out, 6'h20);
        pressed[0][0] = 1'b1;
        repeat (800) @(negedge clk);
        check(hs_out == 1'b1, "R5", "masked-line key starts nothing", hs_out, 1);
        pressed[5][2] = 1'b1;
        wait_start(c0);
        expect_request(c0, "R2");
        pressed = '0;
        read_expect(30'h1 << 27, 1'b1, "R7");
        save_mode = 2'b10;
        @(negedge clk);
        check(drive_out == 6'b110000, "R5", "save 2 idle drive", drive_out, 6'h30);
        pressed[4][1] = 1'b1; pressed[3][3] = 1'b1;
        wait_start(c0);
        expect_request(c0, "R2");
        pressed = '0;
        read_expect(30'h1 << 21, 1'b1, "R7");
        save_mode = 2'b11;
        @(negedge clk);
        check(drive_out == 6'h3F, "R5", "save 3 idle drive", drive_out, 6'h3F);
        pressed[0][0] = 1'b1;
        wait_start(c0);
        expect_request(c0, "R2");
        pressed = '0;
        read_expect(30'h1, 1'b1, "R8");
        save_mode = 2'b00;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_no_scan_before_enable;
        t_basic_scan;
        t_hold_and_write;
        t_disagree;
        t_release_mid;
        t_key_modes;
        t_save_modes;
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule